// File: doc/BRIEF.md
# Configuration Readback Signature Checker

This block watches a serial configuration readback stream and decides, once per pass, whether the configuration memory still holds what it should. Each incoming bit comes with a class flag. Bits that change in normal operation, such as RAM contents, capture flops and filler, are flagged as excluded and dropped. The remaining bits are packed into 8-bit words, and each complete word is folded into a seeded 8-bit parallel signature register.

When the readback source signals the end of a pass, the accumulated signature is compared against a golden value set by a parameter. A match produces a one-cycle pass pulse. A mismatch produces a one-cycle fail pulse, which doubles as the request to refresh the configuration. It also advances a saturating error counter.

Passes run in one of two modes. In the periodic mode, each pass begins on a start request. In the continuous mode, passes follow one another with no request.

Top module: `crb_sig_checker`

## Requirements
- R1: After reset, busy_o, pass_o and fail_o are 0 and err_cnt_o is 0.
- R2: A bit is accepted only in a cycle where a pass is active, rb_vld_i=1, rb_keep_i=1 and rb_done_i=0. All other bits have no effect on the signature.
- R3: Accepted bits are packed most significant bit first. The first accepted bit of a word lands in word bit 7. Every 8th accepted bit completes a word, and that word is folded into the signature.
- R4: The signature register is loaded with 8'h95 at the start of every pass.
- R5: For each completed word w, the signature q is updated to next[0]=q[6]^q[7]^w[0] and next[i]=q[i-1]^w[i] for i=1..7.
- R6: rb_done_i during an active pass ends it. One cycle later, exactly one of pass_o (signature equals GOLDEN, default 8'h5A) or fail_o (mismatch, i.e. refresh request) is high, for one cycle only.
- R7: Accepted bits that do not complete a word before rb_done_i are discarded. The result depends only on complete words.
- R8: err_cnt_o increments by one with each fail_o pulse and holds at 255.
- R9: With cont_mode_i=0, start_i in an idle cycle makes busy_o high from the next cycle. start_i during an active pass is ignored.
- R10: With cont_mode_i=1, a pass begins from idle with no start_i. After rb_done_i, a fresh pass starting from the seed begins at once, and busy_o stays high.
- R11: rb_done_i and readback bits while idle produce no pulse and leave err_cnt_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cont_mode_i | input | 1 | 1: back-to-back passes; 0: passes on request |
| start_i | input | 1 | Pass start request (periodic mode) |
| rb_vld_i | input | 1 | Readback bit present this cycle |
| rb_bit_i | input | 1 | Readback bit value |
| rb_keep_i | input | 1 | 1: bit is usable; 0: bit is excluded |
| rb_done_i | input | 1 | End of the readback pass |
| busy_o | output | 1 | Pass active |
| pass_o | output | 1 | One-cycle pulse: signature matched |
| fail_o | output | 1 | One-cycle pulse: mismatch, refresh request |
| err_cnt_o | output | 8 | Saturating count of failed passes |

## Verification
A wrong internal signature state stays hidden until the end of a pass. It then shows up as a swapped pass_o/fail_o pulse, one cycle after rb_done_i, together with an err_cnt_o step that should or should not have happened. The stimulus therefore closes most passes with a word chosen so that the correct signature lands exactly on the golden value. Any error in the seed, the update taps, the bit packing order or the exclusion filter then turns an expected pass into a fail on that same pass. A wrong packing counter shows up the same way once a pass has a trailing partial word. A wrong start or mode decision shows on busy_o one cycle after the stimulus.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;
endpackage

// File: rtl/crb_packer.sv
module crb_packer #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_vld_i,
  input  logic              keep_i,
  input  logic              bit_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept;

  assign accept     = en_i & bit_vld_i & keep_i;
  assign word_o     = {sr_q, bit_i};
  assign word_vld_o = accept && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      sr_q  <= word_o[WORD_W-2:0];
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: excluded or absent bits never advance packing
  p_drop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(en_i && bit_vld_i && keep_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/crb_psg.sv
module crb_psg #(
  parameter int                WORD_W = 8,
  parameter logic [WORD_W-1:0] SEED   = 8'h95,
  parameter logic [WORD_W-1:0] TAPS   = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] sig_o
);
  logic [WORD_W-1:0] sig_q, sig_d;

  assign sig_d[0] = ^(sig_q & TAPS) ^ word_i[0];
  for (genvar i = 1; i < WORD_W; i++) begin : g_shift
    assign sig_d[i] = sig_q[i-1] ^ word_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= SEED;
    else if (load_i) sig_q <= SEED;
    else if (upd_i)  sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  p_seed_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sig_q == SEED));
  p_sig_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !upd_i) |=> $stable(sig_q));
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int                WORD_W = 8,
  parameter int                ERR_W  = 8,
  parameter logic [WORD_W-1:0] GOLDEN = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_mode_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] sig_i,
  output logic              load_o,
  output logic              en_o,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  run_st_e          st_q, st_d;
  logic             launch, finish, match;
  logic             pass_q, fail_q;
  logic [ERR_W-1:0] err_q;

  assign launch = (st_q == ST_IDLE) && (start_i || cont_mode_i);
  assign finish = (st_q == ST_RUN) && done_i;
  assign match  = (sig_i == GOLDEN);
  assign load_o = launch || (finish && cont_mode_i);
  assign en_o   = (st_q == ST_RUN) && !done_i;

  always_comb begin
    st_d = st_q;
    if (finish)      st_d = cont_mode_i ? ST_RUN : ST_IDLE;
    else if (launch) st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      err_q  <= '0;
    end else begin
      st_q   <= st_d;
      pass_q <= finish && match;
      fail_q <= finish && !match;
      if (finish && !match && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign err_cnt_o = err_q;

  p_one_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_q, fail_q}));
  p_result_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_q || fail_q) |-> $past(st_q == ST_RUN && done_i));
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !done_i) |=> (st_q == ST_RUN));
  p_err_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == ERR_MAX) |=> (err_q == ERR_MAX));
  p_err_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && $past(err_q) != ERR_MAX) |-> (err_q == ERR_W'($past(err_q) + 1'b1)));
endmodule

// File: rtl/crb_sig_checker.sv
module crb_sig_checker #(
  parameter int          WORD_W = 8,
  parameter int          ERR_W  = 8,
  parameter logic [7:0]  SEED   = 8'h95,
  parameter logic [7:0]  TAPS   = 8'hC0,
  parameter logic [7:0]  GOLDEN = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cont_mode_i,
  input  logic             start_i,
  input  logic             rb_vld_i,
  input  logic             rb_bit_i,
  input  logic             rb_keep_i,
  input  logic             rb_done_i,
  output logic             busy_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic              load, en, word_vld;
  logic [WORD_W-1:0] word, sig;

  crb_packer #(.WORD_W(WORD_W)) u_packer (
    .clk_i, .rst_ni,
    .clr_i     (load),
    .en_i      (en),
    .bit_vld_i (rb_vld_i),
    .keep_i    (rb_keep_i),
    .bit_i     (rb_bit_i),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  crb_psg #(.WORD_W(WORD_W), .SEED(WORD_W'(SEED)), .TAPS(WORD_W'(TAPS))) u_psg (
    .clk_i, .rst_ni,
    .load_i(load),
    .upd_i (word_vld),
    .word_i(word),
    .sig_o (sig)
  );

  crb_ctrl #(.WORD_W(WORD_W), .ERR_W(ERR_W), .GOLDEN(WORD_W'(GOLDEN))) u_ctrl (
    .clk_i, .rst_ni,
    .cont_mode_i,
    .start_i,
    .done_i   (rb_done_i),
    .sig_i    (sig),
    .load_o   (load),
    .en_o     (en),
    .busy_o,
    .pass_o,
    .fail_o,
    .err_cnt_o
  );
endmodule

// File: tb/tb_crb_sig_checker.sv
module tb_crb_sig_checker;
  localparam logic [7:0] G    = 8'h5A;
  localparam logic [7:0] SEED = 8'h95;

  logic clk = 0, rst_n = 0;
  logic cont = 0, start = 0, vld = 0, bitv = 0, keep = 0, done = 0;
  logic busy, pass_p, fail_p;
  logic [7:0] err;

  int n_chk = 0, n_bad = 0, exp_err = 0;
  logic [7:0] pw [4];

  always #2 clk = ~clk;

  crb_sig_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .cont_mode_i(cont), .start_i(start),
    .rb_vld_i(vld), .rb_bit_i(bitv), .rb_keep_i(keep), .rb_done_i(done),
    .busy_o(busy), .pass_o(pass_p), .fail_o(fail_p), .err_cnt_o(err));

  // vector: {w0, w1, w2, nwords(1..3), fix_last_to_golden, interleave_dropped}
  localparam logic [27:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00, 2'd1, 1'b1, 1'b0},
    {8'hA5, 8'h3C, 8'h00, 2'd2, 1'b1, 1'b0},
    {8'hFF, 8'h01, 8'h80, 2'd3, 1'b1, 1'b1},
    {8'h12, 8'h34, 8'h56, 2'd3, 1'b0, 1'b0},
    {8'h5A, 8'h00, 8'h00, 2'd1, 1'b0, 1'b1},
    {8'hC3, 8'h7E, 8'h00, 2'd2, 1'b1, 1'b1}
  };

  function automatic logic [7:0] step(logic [7:0] q, logic [7:0] w);
    return {q[6:0], q[6] ^ q[7]} ^ w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic drop);
    if (drop) begin
      @(negedge clk); vld = 1; keep = 0; bitv = ~b;
      @(negedge clk); vld = 0; keep = 1; bitv = ~b;
    end
    @(negedge clk); vld = 1; keep = 1; bitv = b;
  endtask

  task automatic send_words(int n, logic drop);
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) send_bit(pw[k][b], drop);
  endtask

  task automatic pulse_start();
    @(negedge clk); vld = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  // end the pass, then check the result at the following negedge
  task automatic finish_pass(string req, logic exp_pass);
    @(negedge clk); vld = 0; done = 1;
    @(negedge clk); done = 0;
    if (!exp_pass && exp_err < 255) exp_err++;
    chk({req, " pass_o"}, int'(pass_p), int'(exp_pass));
    chk({req, " fail_o"}, int'(fail_p), int'(!exp_pass));
    chk({req, " err_cnt_o"}, int'(err), exp_err);
    @(negedge clk);
    chk({req, " pulse width"}, int'(pass_p | fail_p), 0);
  endtask

  // fill pw[0..n-1] from a start signature; returns expected final signature
  function automatic logic [7:0] build(logic [7:0] w0, w1, w2, int n, logic fix);
    logic [7:0] q = SEED;
    logic [7:0] src [3];
    src[0] = w0; src[1] = w1; src[2] = w2;
    for (int k = 0; k < n; k++) begin
      pw[k] = (fix && k == n - 1) ? (G ^ {q[6:0], q[6] ^ q[7]}) : src[k];
      q = step(q, pw[k]);
    end
    return q;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy_o", int'(busy), 0);
    chk("R1 pass_o|fail_o", int'(pass_p | fail_p), 0);
    chk("R1 err_cnt_o", int'(err), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(busy), 0);

    // R11: done and bits while idle have no effect
    vld = 1; keep = 1; bitv = 1;
    @(negedge clk); done = 1;
    @(negedge clk); done = 0; vld = 0;
    chk("R11 no pulse when idle", int'(pass_p | fail_p), 0);
    chk("R11 err unchanged", int'(err), 0);
    chk("R11 still idle", int'(busy), 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      logic [27:0] e = VEC[v];
      q = build(e[27:20], e[19:12], e[11:4], int'(e[3:2]), e[1]);
      pulse_start();
      chk("R9 busy after start", int'(busy), 1);
      send_words(int'(e[3:2]), e[0]);
      finish_pass(e[0] ? "R2 R5 R6 table" : "R3 R5 R6 table", q == G);
      chk("R9 idle after pass", int'(busy), 0);
    end

    // R7: trailing partial word discarded
    q = build(8'h69, 8'h00, 8'h00, 2, 1'b1);
    pulse_start();
    send_words(2, 1'b0);
    for (int b = 0; b < 5; b++) send_bit(b[0], 1'b0);
    finish_pass("R7 partial word", 1'b1);

    // R9: start during an active pass ignored (would reseed)
    q = build(8'hF0, 8'h0F, 8'h00, 2, 1'b1);
    pulse_start();
    send_words(1, 1'b0);
    @(negedge clk); vld = 0; start = 1;
    @(negedge clk); start = 0;
    chk("R9 still busy", int'(busy), 1);
    pw[0] = pw[1];
    send_words(1, 1'b0);
    finish_pass("R9 start ignored", 1'b1);

    // R10: continuous mode, back-to-back passes, fresh seed each
    @(negedge clk); cont = 1;
    @(negedge clk);
    chk("R10 auto start", int'(busy), 1);
    q = build(8'h33, 8'h00, 8'h00, 2, 1'b1);
    send_words(2, 1'b0);
    finish_pass("R10 first pass R4", 1'b1);
    chk("R10 busy kept", int'(busy), 1);
    q = build(8'hE7, 8'h00, 8'h00, 2, 1'b1);
    send_words(2, 1'b1);
    @(negedge clk); vld = 0; done = 1; cont = 0;
    @(negedge clk); done = 0;
    chk("R10 R4 reseeded pass", int'(pass_p), 1);
    @(negedge clk);
    chk("R10 stop when mode cleared", int'(busy), 0);

    // R8: saturation of error counter (empty pass ends on seed != golden)
    while (exp_err < 257) begin
      pulse_start();
      @(negedge clk); vld = 0; done = 1;
      @(negedge clk); done = 0;
      if (exp_err < 255) exp_err++; else exp_err = exp_err + 1;
      if (!fail_p) begin n_bad++; $display("FAIL R8 fail_o actual=0 expected=1"); end
      n_chk++;
    end
    chk("R8 saturated at 255", int'(err), 255);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule